// File: doc/BRIEF.md
# Remote-Aware Cache Victim Selector

This block chooses which way of one set of a set-associative cache is replaced when a fill needs room, in a server built from several sockets with memory attached to each one. Lines whose home memory sits behind another socket are costly to fetch again, so the selector tries to keep them. It does this by sparing the oldest line when that line is remote, and replacing the oldest line that belongs to the local socket instead. Each set keeps a small retention count, so a remote line is spared only a bounded number of times before plain recency wins again.

For each request the cache controller supplies the set index and, for every way, the valid bit, the tag and an age, where a larger age means less recently used. It also supplies the local socket number and a bias enable. The home node of a line is the upper field of its tag. The chosen way appears one clock later with a strobe. The block does not maintain ages, tags or data. It only reads them.

Top module: `remote_victim_sel`

## Requirements
- R1: A request (req_vld high at a rising clock edge) gives vict_vld high for exactly the next clock cycle, with vict_way holding the chosen way. vict_vld is low in every other cycle. During reset vict_vld and vict_way are 0.
- R2: The home node of a way is the top NODE_W bits of its tag. A way is remote when that field differs from local_node and local when it is equal.
- R3: If any way is invalid, the lowest-numbered invalid way is chosen, and the set's retention count is left unchanged.
- R4: The least recently used way is the valid way with the largest age; among equal ages the lowest-numbered way wins. With bias_en low and all ways valid, that way is chosen and no count changes.
- R5: With bias_en high, all ways valid and the least recently used way local, that way is chosen and the count is unchanged.
- R6: With bias_en high, all ways valid, the least recently used way remote, at least one local way, and the set's count below H, the least recently used local way is chosen and the count rises by one.
- R7: In the case of R6 but with the count at or above H, the least recently used (remote) way is chosen and the count is cleared to zero.
- R8: With bias_en high and every way valid and remote, the least recently used way is chosen and the count is unchanged.
- R9: Each set has its own count. An update of one set does not affect another, and reset clears every count to zero.
- R10: H defaults to half the associativity, which is 4 for the default of 8 ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Replacement request strobe |
| req_set | input | SET_W (6) | Set index of the request |
| way_valid | input | WAYS (8) | Valid bit of each way |
| way_tag | input | WAYS*TAG_W (160) | Tags of all ways. Way i occupies bits [i*TAG_W +: TAG_W] |
| way_age | input | WAYS*AGE_W (24) | Ages of all ways. Way i occupies bits [i*AGE_W +: AGE_W], and larger means older |
| local_node | input | NODE_W (2) | Socket number of this cache |
| bias_en | input | 1 | Enables remote retention |
| vict_vld | output | 1 | Victim result strobe |
| vict_way | output | IDX_W (3) | Chosen victim way |

## Verification
The directed cases use one fixed age ladder. The only thing changed between them is the home field of each way, the valid bits, local_node or bias_en. Because of this, each case separates one branch of the choice: invalid way, plain recency, local oldest way, spare, evict, or all remote. Spare runs of exactly H, followed by one more request, show where the threshold lies. Interleaving sets and a mid-run reset show that the counts are kept per set and are cleared by reset. Random tags, ages with frequent ties, sparse invalid ways and a mix of bias settings over a few hot sets then exercise the tie-breaking rule and long count histories against a reference model in the bench.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_INVALID,
    SEL_PLAIN,
    SEL_LOCAL_LRU,
    SEL_SPARE,
    SEL_EVICT_RMT,
    SEL_ALL_RMT
  } sel_kind_e;

endpackage

// File: rtl/rvs_home_class.sv
module rvs_home_class #(
  parameter int WAYS   = 8,
  parameter int TAG_W  = 20,
  parameter int NODE_W = 2
) (
  input  logic [WAYS*TAG_W-1:0] way_tag,
  input  logic [NODE_W-1:0]     local_node,
  output logic [WAYS-1:0]       way_rmt
);

  localparam int HOME_LSB = TAG_W - NODE_W;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [NODE_W-1:0] home;
    assign home       = way_tag[g*TAG_W + HOME_LSB +: NODE_W];
    assign way_rmt[g] = (home != local_node);
  end

endmodule

// File: rtl/rvs_oldest_pick.sv
module rvs_oldest_pick #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 3,
  parameter int IDX_W = 3
) (
  input  logic [WAYS-1:0]       cand,
  input  logic [WAYS*AGE_W-1:0] way_age,
  output logic                  found,
  output logic [IDX_W-1:0]      idx
);

  logic [AGE_W-1:0] best_age;

  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!found || (way_age[i*AGE_W +: AGE_W] > best_age))) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        best_age = way_age[i*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/rvs_retain_ctr.sv
module rvs_retain_ctr #(
  parameter int SETS   = 64,
  parameter int SET_W  = 6,
  parameter int CNT_W  = 3,
  parameter int THRESH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             upd_en,
  input  logic             upd_clr
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [SETS];
  logic [CNT_W-1:0] cnt_wr;

  assign rd_cnt = cnt_q[rd_set];

  always_comb begin
    if (upd_clr) begin
      cnt_wr = '0;
    end else if (rd_cnt == CNT_MAX) begin
      cnt_wr = rd_cnt;
    end else begin
      cnt_wr = rd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        cnt_q[s] <= '0;
      end
    end else if (upd_en) begin
      cnt_q[rd_set] <= cnt_wr;
    end
  end

  // R6: an increment is only requested while the set is below threshold
  assert_inc_below_h_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_clr) |-> (int'(rd_cnt) < THRESH));

  // R7: a clear is only requested once the threshold has been reached
  assert_clr_at_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_clr) |-> (int'(rd_cnt) >= THRESH));

endmodule

// File: rtl/remote_victim_sel.sv
module remote_victim_sel #(
  parameter int WAYS   = 8,
  parameter int SETS   = 64,
  parameter int NODE_W = 2,
  parameter int TAG_W  = 20,
  parameter int AGE_W  = $clog2(WAYS),
  parameter int THRESH = WAYS / 2,
  parameter int SET_W  = $clog2(SETS),
  parameter int IDX_W  = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_vld,
  input  logic [SET_W-1:0]      req_set,
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tag,
  input  logic [WAYS*AGE_W-1:0] way_age,
  input  logic [NODE_W-1:0]     local_node,
  input  logic                  bias_en,
  output logic                  vict_vld,
  output logic [IDX_W-1:0]      vict_way
);

  import rvs_pkg::*;

  localparam int CNT_W = (THRESH < 1) ? 1 : $clog2(THRESH + 1);

  logic [WAYS-1:0]  way_rmt;
  logic [WAYS-1:0]  loc_cand;
  logic             all_found;
  logic [IDX_W-1:0] all_idx;
  logic             loc_found;
  logic [IDX_W-1:0] loc_idx;
  logic             all_valid;
  logic [IDX_W-1:0] inv_idx;
  logic [CNT_W-1:0] set_cnt;
  logic             upd_en;
  logic             upd_clr;
  sel_kind_e        sel_kind;
  logic [IDX_W-1:0] pick_idx;

  logic             vld_d, vld_q;
  logic [IDX_W-1:0] way_d, way_q;

  rvs_home_class #(.WAYS(WAYS), .TAG_W(TAG_W), .NODE_W(NODE_W)) u_class (
    .way_tag    (way_tag),
    .local_node (local_node),
    .way_rmt    (way_rmt)
  );

  assign loc_cand  = way_valid & ~way_rmt;
  assign all_valid = &way_valid;

  rvs_oldest_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_all (
    .cand    (way_valid),
    .way_age (way_age),
    .found   (all_found),
    .idx     (all_idx)
  );

  rvs_oldest_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_pick_loc (
    .cand    (loc_cand),
    .way_age (way_age),
    .found   (loc_found),
    .idx     (loc_idx)
  );

  rvs_retain_ctr #(.SETS(SETS), .SET_W(SET_W), .CNT_W(CNT_W), .THRESH(THRESH)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (req_set),
    .rd_cnt  (set_cnt),
    .upd_en  (upd_en),
    .upd_clr (upd_clr)
  );

  // lowest-numbered invalid way
  always_comb begin
    inv_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) begin
        inv_idx = IDX_W'(i);
      end
    end
  end

  // victim decision
  always_comb begin
    sel_kind = SEL_IDLE;
    pick_idx = '0;
    upd_en   = 1'b0;
    upd_clr  = 1'b0;
    if (req_vld) begin
      if (!all_valid) begin
        sel_kind = SEL_INVALID;
        pick_idx = inv_idx;
      end else if (!bias_en) begin
        sel_kind = SEL_PLAIN;
        pick_idx = all_idx;
      end else if (!way_rmt[all_idx]) begin
        sel_kind = SEL_LOCAL_LRU;
        pick_idx = all_idx;
      end else if (!loc_found) begin
        sel_kind = SEL_ALL_RMT;
        pick_idx = all_idx;
      end else if (int'(set_cnt) < THRESH) begin
        sel_kind = SEL_SPARE;
        pick_idx = loc_idx;
        upd_en   = 1'b1;
      end else begin
        sel_kind = SEL_EVICT_RMT;
        pick_idx = all_idx;
        upd_en   = 1'b1;
        upd_clr  = 1'b1;
      end
    end
  end

  // output next state
  always_comb begin
    vld_d = req_vld;
    way_d = way_q;
    if (req_vld) begin
      way_d = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      way_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (req_vld) begin
        way_q <= way_d;
      end
    end
  end

  assign vict_vld = vld_q;
  assign vict_way = way_q;

  // R1: strobe follows a request by exactly one cycle
  assert_vld_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vict_vld == $past(req_vld));

  // R3: when a hole exists the chosen way must be a hole
  assert_invalid_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !all_valid) |-> !way_valid[pick_idx]);

  // R6: a spared decision must name a local, valid way
  assert_spare_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_kind == SEL_SPARE) |-> (!way_rmt[pick_idx] && way_valid[pick_idx]));

  // R4: with all ways valid, the oldest-way search always finds a way
  assert_lru_found_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && all_valid) |-> all_found);

endmodule

// File: tb/test_remote_victim_sel.sv
module test_remote_victim_sel;

  localparam int WAYS   = 8;
  localparam int SETS   = 64;
  localparam int NODE_W = 2;
  localparam int TAG_W  = 20;
  localparam int AGE_W  = 3;
  localparam int SET_W  = 6;
  localparam int IDX_W  = 3;
  localparam int H      = WAYS / 2;

  logic                  clk;
  logic                  rst_n;
  logic                  req_vld;
  logic [SET_W-1:0]      req_set;
  logic [WAYS-1:0]       way_valid;
  logic [WAYS*TAG_W-1:0] way_tag;
  logic [WAYS*AGE_W-1:0] way_age;
  logic [NODE_W-1:0]     local_node;
  logic                  bias_en;
  logic                  vict_vld;
  logic [IDX_W-1:0]      vict_way;

  int checks;
  int fails;
  bit done;
  int mdl_cnt [SETS];

  remote_victim_sel i_remote_victim_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_set    (req_set),
    .way_valid  (way_valid),
    .way_tag    (way_tag),
    .way_age    (way_age),
    .local_node (local_node),
    .bias_en    (bias_en),
    .vict_vld   (vict_vld),
    .vict_way   (vict_way)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int age_of(input int i);
    return int'(way_age[i*AGE_W +: AGE_W]);
  endfunction

  function automatic bit rmt_of(input int i);
    return way_tag[i*TAG_W + TAG_W - NODE_W +: NODE_W] != local_node;
  endfunction

  // reference choice built from the requirements
  function automatic int model_pick(input int s, output int nxt);
    int best;
    int loc;
    nxt = mdl_cnt[s];
    for (int i = 0; i < WAYS; i++) if (!way_valid[i]) return i;
    best = -1;
    for (int i = 0; i < WAYS; i++) if (best < 0 || age_of(i) > age_of(best)) best = i;
    if (!bias_en) return best;
    if (!rmt_of(best)) return best;
    loc = -1;
    for (int i = 0; i < WAYS; i++)
      if (!rmt_of(i) && (loc < 0 || age_of(i) > age_of(loc))) loc = i;
    if (loc < 0) return best;
    if (mdl_cnt[s] < H) begin
      nxt = mdl_cnt[s] + 1;
      return loc;
    end
    nxt = 0;
    return best;
  endfunction

  task automatic set_way(input int i, input bit v, input int home, input int age);
    way_valid[i] = v;
    way_tag[i*TAG_W +: TAG_W] = {NODE_W'(home), (TAG_W-NODE_W)'(i*77 + 13)};
    way_age[i*AGE_W +: AGE_W] = AGE_W'(age);
  endtask

  // ages 0..7 by way, way7 (home 2) and way6 (home 0) remote for node 1, way5 oldest local
  task automatic base_set();
    for (int i = 0; i < WAYS; i++) set_way(i, 1'b1, 1, i);
    set_way(7, 1'b1, 2, 7);
    set_way(6, 1'b1, 0, 6);
    local_node = 2'd1;
    bias_en    = 1'b1;
  endtask

  // called at a falling edge with inputs prepared; returns at the next falling edge
  task automatic do_req(input int s, input string rq, input int hand);
    int e;
    int n;
    req_set = SET_W'(s);
    e = model_pick(s, n);
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    mdl_cnt[s] = n;
    check(vict_vld == 1'b1, {rq, " strobe"}, int'(vict_vld), 1);
    check(int'(vict_way) == e, rq, int'(vict_way), e);
    if (hand >= 0) check(e == hand, {rq, " model"}, e, hand);
  endtask

  task automatic idle_check(input string rq);
    @(negedge clk);
    check(vict_vld == 1'b0, rq, int'(vict_vld), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(vict_vld == 1'b0 && vict_way == '0, "R1 reset outputs", int'(vict_way), 0);
    rst_n = 1'b1;
    for (int s = 0; s < SETS; s++) mdl_cnt[s] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    checks = 0; fails = 0; done = 1'b0;
    req_vld = 1'b0; req_set = '0; way_valid = '1; way_tag = '0; way_age = '0;
    local_node = '0; bias_en = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();
    @(negedge clk);

    // R3: invalid ways win, count untouched (set 7 still spares H times after)
    base_set();
    set_way(5, 1'b0, 1, 5);
    set_way(2, 1'b0, 2, 2);
    do_req(7, "R3 lowest invalid way", 2);
    set_way(2, 1'b1, 1, 2);
    do_req(7, "R3 invalid way", 5);
    idle_check("R1 strobe drops after one cycle");

    // R4: bias off picks plain oldest, no count change
    base_set();
    bias_en = 1'b0;
    do_req(7, "R4 bias off oldest", 7);
    do_req(7, "R4 bias off oldest again", 7);
    bias_en = 1'b1;

    // R6/R7/R10 on set 7: H spares, then eviction and clear
    for (int k = 0; k < H; k++) do_req(7, "R6 R10 spare local", 5);
    do_req(7, "R7 R10 evict at threshold", 7);
    do_req(7, "R7 count cleared", 5);

    // R5 and R8 on set 8 leave the count at zero
    base_set();
    set_way(7, 1'b1, 1, 7);
    do_req(8, "R5 local oldest", 7);
    do_req(8, "R5 local oldest again", 7);
    for (int i = 0; i < WAYS; i++) set_way(i, 1'b1, (i % 2 == 0) ? 2 : 3, i);
    do_req(8, "R8 all remote", 7);
    do_req(8, "R8 all remote again", 7);
    base_set();
    for (int k = 0; k < H; k++) do_req(8, "R5 R8 count unchanged", 5);
    do_req(8, "R5 R8 threshold after", 7);

    // R2: local_node decides the class
    base_set();
    local_node = 2'd2;
    do_req(10, "R2 home equals local", 7);
    local_node = 2'd0;
    do_req(10, "R2 other local way", 6);

    // R4: equal ages resolve to lowest way
    for (int i = 0; i < WAYS; i++) set_way(i, 1'b1, 3, 3);
    local_node = 2'd1;
    bias_en = 1'b0;
    do_req(10, "R4 tie lowest way", 0);
    set_way(4, 1'b1, 3, 5);
    set_way(6, 1'b1, 3, 5);
    do_req(10, "R4 tie among oldest", 4);

    // R9: independent sets
    base_set();
    do_req(11, "R9 set11 spare", 5);
    do_req(11, "R9 set11 spare", 5);
    for (int k = 0; k < H; k++) do_req(12, "R9 set12 spare", 5);
    do_req(12, "R9 set12 evict", 7);
    do_req(11, "R9 set11 spare", 5);
    do_req(11, "R9 set11 spare", 5);
    do_req(11, "R9 set11 evict", 7);

    // R9: reset clears counts
    do_req(13, "R9 set13 spare", 5);
    do_req(13, "R9 set13 spare", 5);
    do_reset();
    base_set();
    for (int k = 0; k < H; k++) do_req(13, "R9 after reset spare", 5);
    do_req(13, "R9 after reset evict", 7);

    // random phase over a few hot sets
    for (int v = 0; v < 4000; v++) begin
      for (int i = 0; i < WAYS; i++)
        set_way(i, ($urandom % 16) != 0, int'($urandom % 4), int'($urandom % 8));
      local_node = NODE_W'($urandom % 4);
      bias_en    = ($urandom % 4) != 0;
      do_req(int'($urandom % 4), "R4 R6 R7 random", -1);
      if ($urandom % 8 == 0) idle_check("R1 random idle");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule